// File: doc/BRIEF.md
# Burst Mean and Midrange Unit

This unit takes a fixed burst of eight unsigned bytes and produces two statistics over them. The first is the arithmetic mean, truncated toward zero. The second is the midrange, which is half the sum of the largest and the smallest byte, also truncated. A synchronous arming input starts each burst. Software or an upstream controller raises it for one or more cycles and then lowers it. The first rising edge on which it is seen low is the first sample edge, and the seven edges after it take the other seven bytes.

The unit keeps no copy of the samples. It keeps a running sum, a running minimum and a running maximum. On the edge after the eighth sample it loads both results into output registers and raises a one-cycle valid flag. The results stay on the outputs until another burst completes. If the arming input is raised again before results are published, the partial burst is thrown away and a fresh burst begins once the input drops.

Top module: `eight_stat_top`

## Requirements
- R1: While rst_ni is low and after its release, mean_o and mid_o read 0 and valid_o reads 0 until a burst completes.
- R2: After arm_i has been high on at least one rising edge, the first rising edge with arm_i low samples data_i as byte 1. Each of the next seven edges samples one more byte, so exactly eight bytes are taken.
- R3: mean_o equals the unsigned sum of the eight bytes, held in 11 bits without loss, divided by 8 and truncated (sum shifted right by 3).
- R4: mid_o equals (largest byte + smallest byte), formed in 9 bits, shifted right by 1.
- R5: valid_o is high for exactly one cycle, starting at the edge after the eighth sample edge (the ninth edge after arm_i drops). The new mean_o and mid_o appear in that same cycle, and valid_o is low on the eighth sample edge.
- R6: Outside the cycle valid_o rises, mean_o and mid_o hold their last values.
- R7: Raising arm_i before results are published discards the partial burst. No valid_o follows the edge that samples arm_i high, and the next results cover only the eight bytes taken after arm_i drops again.
- R8: data_i is ignored while the unit is idle and on the edges after the eighth sample. Outputs do not change and valid_o stays low.
- R9: The running minimum restarts at 8'hFF and the running maximum restarts at 8'h00 for every burst, so earlier bursts never affect the midrange.
- R10: arm_i may stay high for any number of cycles. Sampling begins only on the first edge at which it is seen low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Synchronous arm/restart pulse; the burst starts after it falls |
| data_i | input | 8 | Unsigned sample byte |
| mean_o | output | 8 | Truncated mean of the last burst |
| mid_o | output | 8 | Truncated midrange of the last burst |
| valid_o | output | 1 | One-cycle flag: new results present |

## Verification
The bound checker watches several properties on every cycle. It checks that valid_o is a single-cycle pulse and that both results hold when no publish occurs. It checks that arming suppresses publishing on the following edge. It checks that a publish comes only after the sample counter has reached eight, that the counter never exceeds eight, and that the tracked minimum never exceeds the tracked maximum once a sample is in. The arithmetic cannot be seen from those invariants, so the bench scenarios are needed for it: exact mean and midrange values, truncation, and per-burst restart of the extremes. The same holds for the exact publish cycle, the discarding of an aborted burst, long arming pulses, and data being ignored while idle. The bench sweeps every constant-valued burst, a set of extreme mixes and a long pseudo-random series.

// File: rtl/eight_stat_pkg.sv
package eight_stat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_CAPT = 2'd2,
    ST_DONE = 2'd3
  } stat_state_e;
endpackage

// File: rtl/stat_ctrl.sv
module stat_ctrl
  import eight_stat_pkg::*;
#(
  parameter int N_SMP = 8,
  parameter int CNT_W = $clog2(N_SMP + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  output logic             clr_o,
  output logic             cap_o,
  output logic             pub_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_SMP - 1);

  stat_state_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic last_cap;

  always_comb begin
    clr_o    = arm_i;
    cap_o    = !arm_i && (st_q == ST_ARM || st_q == ST_CAPT);
    pub_o    = !arm_i && (st_q == ST_DONE);
    last_cap = cap_o && (cnt_q == LAST_IDX);
  end

  always_comb begin
    st_d = st_q;
    if (arm_i) begin
      st_d = ST_ARM;  // restart discards anything in flight
    end else begin
      unique case (st_q)
        ST_IDLE: st_d = ST_IDLE;
        ST_ARM,
        ST_CAPT: st_d = last_cap ? ST_DONE : ST_CAPT;
        ST_DONE: st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (clr_o)      cnt_q <= '0;
      else if (cap_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/stat_accum.sv
module stat_accum #(
  parameter int DATA_W = 8,
  parameter int SUM_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [SUM_W-1:0]  sum_o
);
  logic [SUM_W-1:0] sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= '0;
    else if (clr_i) sum_q <= '0;
    else if (cap_i) sum_q <= sum_q + SUM_W'(data_i);
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/stat_extrema.sv
module stat_extrema #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] min_o,
  output logic [DATA_W-1:0] max_o
);
  logic [DATA_W-1:0] min_q, max_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q <= '1;
      max_q <= '0;
    end else if (clr_i) begin
      min_q <= '1;
      max_q <= '0;
    end else if (cap_i) begin
      if (data_i < min_q) min_q <= data_i;
      if (data_i > max_q) max_q <= data_i;
    end
  end

  assign min_o = min_q;
  assign max_o = max_q;
endmodule

// File: rtl/eight_stat_top.sv
module eight_stat_top #(
  parameter int DATA_W = 8,
  parameter int N_SMP  = 8   // power of two: mean is a pure shift
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] mean_o,
  output logic [DATA_W-1:0] mid_o,
  output logic              valid_o
);
  localparam int SHIFT = $clog2(N_SMP);
  localparam int SUM_W = DATA_W + SHIFT;
  localparam int CNT_W = $clog2(N_SMP + 1);

  logic             clr_w, cap_w, pub_w;
  logic [CNT_W-1:0] cnt_w;
  logic [SUM_W-1:0] sum_w;
  logic [DATA_W-1:0] min_w, max_w;
  logic [DATA_W:0]   ext_w;
  logic [DATA_W-1:0] mean_q, mid_q;
  logic              valid_q;

  stat_ctrl #(.N_SMP(N_SMP), .CNT_W(CNT_W)) i_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .arm_i (arm_i),
    .clr_o (clr_w),
    .cap_o (cap_w),
    .pub_o (pub_w),
    .cnt_o (cnt_w)
  );

  stat_accum #(.DATA_W(DATA_W), .SUM_W(SUM_W)) i_accum (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_w),
    .cap_i (cap_w),
    .data_i(data_i),
    .sum_o (sum_w)
  );

  stat_extrema #(.DATA_W(DATA_W)) i_extrema (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_w),
    .cap_i (cap_w),
    .data_i(data_i),
    .min_o (min_w),
    .max_o (max_w)
  );

  assign ext_w = {1'b0, max_w} + {1'b0, min_w};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mean_q  <= '0;
      mid_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= pub_w;
      if (pub_w) begin
        mean_q <= sum_w[SUM_W-1:SHIFT];
        mid_q  <= ext_w[DATA_W:1];
      end
    end
  end

  assign mean_o  = mean_q;
  assign mid_o   = mid_q;
  assign valid_o = valid_q;
endmodule

module eight_stat_chk #(
  parameter int DATA_W = 8,
  parameter int N_SMP  = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              arm_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] mean_o,
  input logic [DATA_W-1:0] mid_o,
  input logic [CNT_W-1:0]  cnt_w,
  input logic [DATA_W-1:0] min_w,
  input logic [DATA_W-1:0] max_w
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R5
  AST_RESULTS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(mean_o) && $stable(mid_o))); // R6
  AST_ARM_BLOCKS_PUBLISH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> !valid_o); // R7
  AST_PUBLISH_AFTER_EIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(cnt_w) == CNT_W'(N_SMP))); // R2
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_w <= CNT_W'(N_SMP)); // R2
  AST_MIN_LE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_w != '0) |-> (min_w <= max_w)); // R9
endmodule

bind eight_stat_top eight_stat_chk #(.DATA_W(DATA_W), .N_SMP(N_SMP), .CNT_W(CNT_W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .arm_i  (arm_i),
  .valid_o(valid_o),
  .mean_o (mean_o),
  .mid_o  (mid_o),
  .cnt_w  (cnt_w),
  .min_w  (min_w),
  .max_w  (max_w)
);

// File: tb/test_eight_stat_top.sv
module test_eight_stat_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       arm_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic [7:0] mean_o, mid_o;
  logic       valid_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] smp [8];
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk_i = ~clk_i;

  eight_stat_top i_eight_stat_top (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm_i),
    .data_i (data_i),
    .mean_o (mean_o),
    .mid_o  (mid_o),
    .valid_o(valid_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:16];
  endfunction

  // arm for arm_len cycles, feed smp[], check publish timing and values
  task automatic run_burst(input int arm_len);
    int sum = 0;
    int mn = 255;
    int mx = 0;
    for (int i = 0; i < 8; i++) begin
      sum += smp[i];
      if (smp[i] < mn) mn = smp[i];
      if (smp[i] > mx) mx = smp[i];
    end
    arm_i = 1'b1;
    data_i = rnd();
    for (int k = 0; k < arm_len; k++) @(negedge clk_i);
    arm_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      data_i = smp[i];
      @(negedge clk_i);
    end
    chk("R5 valid low on eighth sample edge", valid_o, 0);
    data_i = rnd();  // post-burst data, R8
    @(negedge clk_i);
    chk("R5 valid on ninth edge", valid_o, 1);
    chk("R3 mean", mean_o, sum / 8);
    chk("R4 midrange", mid_o, (mx + mn) / 2);
    data_i = rnd();
    @(negedge clk_i);
    chk("R5 valid one cycle", valid_o, 0);
    chk("R6 mean held", mean_o, sum / 8);
    chk("R6 mid held", mid_o, (mx + mn) / 2);
  endtask

  initial begin
    #600000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    if (!done) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 mean reset", mean_o, 0);
    chk("R1 mid reset", mid_o, 0);
    chk("R1 valid reset", valid_o, 0);
    rst_ni = 1'b1;
    for (int k = 0; k < 4; k++) begin  // idle data ignored, R8
      data_i = rnd();
      @(negedge clk_i);
      chk("R8 idle no valid", valid_o, 0);
      chk("R1 mean after release", mean_o, 0);
    end

    // R2 R3 R4: every constant burst
    for (int v = 0; v < 256; v++) begin
      for (int i = 0; i < 8; i++) smp[i] = 8'(v);
      run_burst(1);
    end

    // truncation and extreme mixes
    for (int i = 0; i < 8; i++) smp[i] = 8'h00;
    smp[3] = 8'd7;
    run_burst(1);  // R3 mean 0, R4 mid 3
    for (int i = 0; i < 8; i++) smp[i] = 8'hFF;
    smp[0] = 8'h00;
    run_burst(2);  // R4 mid 127, R10
    // R9: high burst then low burst
    for (int i = 0; i < 8; i++) smp[i] = 8'd200;
    run_burst(1);
    for (int i = 0; i < 8; i++) smp[i] = 8'd10;
    run_burst(1);

    // R10: long arm pulses
    for (int L = 3; L < 9; L++) begin
      for (int i = 0; i < 8; i++) smp[i] = rnd();
      run_burst(L);
    end

    // R7: abort partway, then full burst
    for (int a = 1; a < 9; a++) begin
      arm_i = 1'b1;
      @(negedge clk_i);
      arm_i = 1'b0;
      for (int k = 0; k < a; k++) begin
        data_i = 8'hFF;
        @(negedge clk_i);
        chk("R7 no valid in aborted burst", valid_o, 0);
      end
      for (int i = 0; i < 8; i++) smp[i] = rnd() >> 1;
      run_burst(1);
    end

    // R8: idle data after a burst leaves outputs unchanged
    for (int i = 0; i < 8; i++) smp[i] = 8'(i * 30);
    run_burst(1);
    for (int k = 0; k < 10; k++) begin
      data_i = rnd();
      @(negedge clk_i);
      chk("R8 idle valid low", valid_o, 0);
      chk("R8 idle mean", mean_o, (0 + 30 + 60 + 90 + 120 + 150 + 180 + 210) / 8);
      chk("R8 idle mid", mid_o, 105);
    end

    // pseudo-random sweep
    for (int b = 0; b < 400; b++) begin
      for (int i = 0; i < 8; i++) smp[i] = rnd();
      run_burst(1 + (b % 3));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule